// File: doc/BRIEF.md
# SPI Burst Master

This block is a byte-wide SPI master. A processor reaches it through a small register window. The processor queues outgoing bytes in a transmit FIFO and programs two 24-bit counts. The first count is the length of the whole burst in bytes. The second is how many of those bytes are taken from the transmit FIFO; every byte of the burst beyond that count goes out as zero. The processor then sets a start bit. The engine clocks the burst out with the selected clock polarity, clock phase and bit order. Each byte captured on the input line is placed in a receive FIFO. Setting a discard bit keeps captured bytes out of that FIFO, which suits write-only traffic.

The serial clock rate is set outside the block. An enable input, `sck_tick`, marks each half period of the serial clock. The block drives one of four chip-select lines. In automatic mode it drives the line itself. In manual mode a control bit sets the line's level directly. A polarity bit decides the level at which every line counts as active. The same bit sets the level of every line that is not selected. When the burst ends, a sticky completion flag is raised, and the interrupt output can be enabled for it.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, the control word (offset 0x08), the FIFO status word (offset 0x28), `spi_sck`, `spi_cs` and `irq` all read zero.
- R2: A write to offset 0x04 pushes `bus_wdata[7:0]` into the transmit FIFO. FIFO status bits 22:16 hold the transmit fill level and bits 6:0 hold the receive fill level. Each FIFO holds 64 bytes, and a push into a full FIFO is dropped.
- R3: A control write with bit 8 set empties the transmit FIFO. A control write with bit 9 set empties the receive FIFO.
- R4: A control write with both bit 10 (go) and bit 0 (enable) set starts a burst. Control bit 10 reads 1 while the burst runs and reads 0 once it has ended. If enable is 0 in that write, no burst starts and no completion is flagged.
- R5: A burst shifts exactly burst-count bytes (offset 0x20), with 8 serial clock cycles per byte. Between bursts `spi_sck` rests at CPOL (control bit 3). When CPHA (control bit 2) is 0, data is valid on the first edge of each clock cycle. When CPHA is 1, data is valid on the second edge.
- R6: Control bit 6 set sends and receives least significant bit first. When it is clear, the most significant bit goes first.
- R7: The first transmit-count bytes (offset 0x24) come from the transmit FIFO in order. Every later byte of the burst is 0x00.
- R8: Each byte sampled on `spi_miso` is pushed into the receive FIFO, and a read of offset 0x00 pops it. When control bit 15 is set, no received byte enters the FIFO.
- R9: Control bits 13:12 pick the chip-select line. In automatic mode that line is at its active level only while a burst runs. The active level is low when control bit 4 is set and high when it is clear. All other lines stay at the inactive level.
- R10: When control bit 16 is set, the picked line follows control bit 17 directly. The other lines keep the inactive level given by bit 4.
- R11: Interrupt status bit 16 (offset 0x10) is set when a burst ends, and writing 1 to it clears it. `irq` equals that bit ANDed with interrupt-enable bit 16 (offset 0x0C).
- R12: Starting with a burst count of zero sets the completion flag within a few cycles. No serial clock edge is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; pops the receive FIFO at offset 0x00 |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| sck_tick | input | 1 | Enable marking one serial-clock half period |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Chip-select lines |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest case to reach from the ports is the last bit of a byte when CPHA is 1. That bit is sampled on the same core edge that loads the next byte, or that ends the burst and deselects the line. The bench loops `spi_mosi` back to `spi_miso`. An independent edge monitor rebuilds each byte. It qualifies each edge with the chip-select state seen one sample earlier, so that this final edge is still counted. Every burst is read back through the receive FIFO, and the bursts cover all four clock modes, both bit orders, a transmit count shorter than the burst, and the discard setting.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  typedef logic [7:0] byte_t;
  typedef enum logic {ENG_IDLE = 1'b0, ENG_SHIFT = 1'b1} eng_state_t;

  localparam logic [5:0] OFF_RXD   = 6'h00;
  localparam logic [5:0] OFF_TXD   = 6'h04;
  localparam logic [5:0] OFF_CTRL  = 6'h08;
  localparam logic [5:0] OFF_IEN   = 6'h0C;
  localparam logic [5:0] OFF_IST   = 6'h10;
  localparam logic [5:0] OFF_BURST = 6'h20;
  localparam logic [5:0] OFF_TXCNT = 6'h24;
  localparam logic [5:0] OFF_FSTAT = 6'h28;

  localparam int CB_EN      = 0;
  localparam int CB_MSTR    = 1;
  localparam int CB_CPHA    = 2;
  localparam int CB_CPOL    = 3;
  localparam int CB_ACTLOW  = 4;
  localparam int CB_LSB     = 6;
  localparam int CB_TXCLR   = 8;
  localparam int CB_RXCLR   = 9;
  localparam int CB_GO      = 10;
  localparam int CB_SEL     = 12;
  localparam int CB_DISCARD = 15;
  localparam int CB_MANUAL  = 16;
  localparam int CB_LEVEL   = 17;
  localparam int IB_DONE    = 16;
  localparam int FS_TXPOS   = 16;

  // bit presented first on the line for the chosen order
  function automatic logic sb_head(input logic lsb, input byte_t b);
    return lsb ? b[0] : b[7];
  endfunction

  // remove the bit just presented
  function automatic byte_t sb_drop(input logic lsb, input byte_t b);
    return lsb ? {1'b0, b[7:1]} : {b[6:0], 1'b0};
  endfunction

  // insert a captured bit
  function automatic byte_t sb_take(input logic lsb, input byte_t b, input logic d);
    return lsb ? {d, b[7:1]} : {b[6:0], d};
  endfunction
endpackage

// File: rtl/spi_burst_fifo.sv
module spi_burst_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               push,
  input  logic [W-1:0]       wdata,
  input  logic               pop,
  output logic [W-1:0]       rdata,
  output logic [$clog2(DEPTH):0] count,
  output logic               full,
  output logic               empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  always_comb begin
    full    = (count == (AW+1)'(DEPTH));
    empty   = (count == '0);
    do_push = push && !full && !clr;
    do_pop  = pop && !empty && !clr;
    rdata   = mem[rp];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (full && push && !pop && !clr) |=> full); // R2
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) clr |=> empty); // R3
endmodule

// File: rtl/spi_burst_shifter.sv
module spi_burst_shifter
  import spi_burst_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic             cfg_lsb,
  input  logic             cfg_discard,
  input  logic [CNT_W-1:0] burst_len,
  input  logic [CNT_W-1:0] tx_len,
  input  byte_t            tx_head,
  input  logic             tx_empty,
  input  logic             miso,
  output logic             tx_pop,
  output logic             rx_push,
  output byte_t            rx_byte,
  output logic             busy,
  output logic             done,
  output logic             sck,
  output logic             mosi
);
  eng_state_t       state;
  logic             cpol_q, cpha_q, lsb_q, discard_q;
  logic [CNT_W-1:0] remain, tx_left, left_now;
  byte_t            txs, rxs, load_byte;
  logic             mosi_q, half;
  logic [2:0]       bitcnt;
  logic             start_ok, byte_fire, last_byte, load_now, capture, launch;
  logic             load_cpha, load_lsb;

  // named events for the assertions
  always_comb begin
    busy      = (state == ENG_SHIFT);
    start_ok  = !busy && start;
    byte_fire = busy && tick && half && (bitcnt == 3'd7);
    last_byte = byte_fire && (remain == CNT_W'(1));
    done      = (start_ok && (burst_len == '0)) || last_byte;            // R12
    load_now  = (start_ok && (burst_len != '0)) || (byte_fire && !last_byte);
    left_now  = busy ? tx_left : tx_len;
    tx_pop    = load_now && (left_now != '0) && !tx_empty;               // R7
    load_byte = tx_pop ? tx_head : 8'h00;
    load_cpha = busy ? cpha_q : cfg_cpha;
    load_lsb  = busy ? lsb_q : cfg_lsb;
    capture   = busy && tick && (half == cpha_q);                        // R5
    launch    = busy && tick && (cpha_q ? !half : (half && (bitcnt != 3'd7)));
    rx_byte   = capture ? sb_take(lsb_q, rxs, miso) : rxs;
    rx_push   = byte_fire && !discard_q;                                 // R8
    sck       = busy ? (cpol_q ^ half) : cfg_cpol;
    mosi      = mosi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ENG_IDLE;
      cpol_q    <= 1'b0;
      cpha_q    <= 1'b0;
      lsb_q     <= 1'b0;
      discard_q <= 1'b0;
      remain    <= '0;
      tx_left   <= '0;
      txs       <= '0;
      rxs       <= '0;
      mosi_q    <= 1'b0;
      half      <= 1'b0;
      bitcnt    <= '0;
    end else begin
      if (start_ok) begin
        cpol_q    <= cfg_cpol;
        cpha_q    <= cfg_cpha;
        lsb_q     <= cfg_lsb;
        discard_q <= cfg_discard;
        remain    <= burst_len;
        half      <= 1'b0;
        bitcnt    <= '0;
        if (burst_len != '0) state <= ENG_SHIFT;
      end
      if (busy && tick) begin
        half <= !half;
        if (half) bitcnt <= bitcnt + 3'd1;
      end
      if (capture)   rxs <= rx_byte;
      if (byte_fire) remain <= remain - CNT_W'(1);
      if (last_byte) state <= ENG_IDLE;
      if (launch) begin
        mosi_q <= sb_head(lsb_q, txs);
        txs    <= sb_drop(lsb_q, txs);
      end
      if (load_now) begin
        tx_left <= left_now - CNT_W'(left_now != '0);
        if (!load_cpha) begin
          mosi_q <= sb_head(load_lsb, load_byte);
          txs    <= sb_drop(load_lsb, load_byte);
        end else begin
          txs <= load_byte;
        end
      end
    end
  end

  AST_DONE_IDLES: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R4
  AST_REMAIN_LIVE: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (remain != '0)); // R5
endmodule

// File: rtl/spi_burst_csel.sv
module spi_burst_csel #(
  parameter int NCS = 4,
  parameter int SW  = 2
) (
  input  logic [SW-1:0]  sel,
  input  logic           act_low,
  input  logic           manual,
  input  logic           level,
  input  logic           busy,
  output logic [NCS-1:0] cs
);
  // inactive level equals act_low; busy flips the picked line to active
  for (genvar i = 0; i < NCS; i++) begin : g_line
    assign cs[i] = (sel == SW'(i)) ? (manual ? level : (busy ^ act_low)) : act_low; // R9 R10
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = 24,
  parameter int NCS        = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [5:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic           sck_tick,
  output logic           spi_sck,
  output logic           spi_mosi,
  input  logic           spi_miso,
  output logic [NCS-1:0] spi_cs,
  output logic           irq
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;
  localparam int SW = (NCS > 1) ? $clog2(NCS) : 1;

  logic             en_q, mstr_q, cpha_q, cpol_q, al_q, lsb_q, discard_q, manual_q, level_q;
  logic [SW-1:0]    sel_q;
  logic             ien_q, ist_q, go_q;
  logic [CNT_W-1:0] burst_q, txcnt_q;

  logic             wr_ctrl, wr_ist, tx_clr, rx_clr, tx_push, rx_pop;
  logic             eng_tx_pop, eng_rx_push, eng_busy, eng_done;
  byte_t            eng_rx_byte, tx_head, rx_head;
  logic [CW-1:0]    tx_count, rx_count;
  logic             tx_full, tx_empty, rx_full, rx_empty;

  always_comb begin
    wr_ctrl = bus_wr && (bus_addr == OFF_CTRL);
    wr_ist  = bus_wr && (bus_addr == OFF_IST);
    tx_clr  = wr_ctrl && bus_wdata[CB_TXCLR];                 // R3
    rx_clr  = wr_ctrl && bus_wdata[CB_RXCLR];                 // R3
    tx_push = bus_wr && (bus_addr == OFF_TXD);                // R2
    rx_pop  = bus_rd && (bus_addr == OFF_RXD);                // R8
  end

  spi_burst_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txf (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .wdata(bus_wdata[7:0]),
    .pop(eng_tx_pop), .rdata(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  spi_burst_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxf (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(eng_rx_push), .wdata(eng_rx_byte),
    .pop(rx_pop), .rdata(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  spi_burst_shifter #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(sck_tick), .start(go_q),
    .cfg_cpol(cpol_q), .cfg_cpha(cpha_q), .cfg_lsb(lsb_q), .cfg_discard(discard_q),
    .burst_len(burst_q), .tx_len(txcnt_q), .tx_head(tx_head), .tx_empty(tx_empty),
    .miso(spi_miso), .tx_pop(eng_tx_pop), .rx_push(eng_rx_push), .rx_byte(eng_rx_byte),
    .busy(eng_busy), .done(eng_done), .sck(spi_sck), .mosi(spi_mosi)
  );

  spi_burst_csel #(.NCS(NCS), .SW(SW)) u_cs (
    .sel(sel_q), .act_low(al_q), .manual(manual_q), .level(level_q),
    .busy(eng_busy), .cs(spi_cs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; mstr_q <= 1'b0; cpha_q <= 1'b0; cpol_q <= 1'b0;
      al_q <= 1'b0; lsb_q <= 1'b0; discard_q <= 1'b0;
      manual_q <= 1'b0; level_q <= 1'b0; sel_q <= '0;
      ien_q <= 1'b0; ist_q <= 1'b0; go_q <= 1'b0;
      burst_q <= '0; txcnt_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q      <= bus_wdata[CB_EN];
        mstr_q    <= bus_wdata[CB_MSTR];
        cpha_q    <= bus_wdata[CB_CPHA];
        cpol_q    <= bus_wdata[CB_CPOL];
        al_q      <= bus_wdata[CB_ACTLOW];
        lsb_q     <= bus_wdata[CB_LSB];
        sel_q     <= bus_wdata[CB_SEL +: SW];
        discard_q <= bus_wdata[CB_DISCARD];
        manual_q  <= bus_wdata[CB_MANUAL];
        level_q   <= bus_wdata[CB_LEVEL];
      end
      // start waits one cycle so the engine sees the written mode bits (R4)
      go_q <= wr_ctrl && bus_wdata[CB_GO] && bus_wdata[CB_EN] && !eng_busy && !go_q;
      if (bus_wr && (bus_addr == OFF_IEN))   ien_q   <= bus_wdata[IB_DONE];
      if (bus_wr && (bus_addr == OFF_BURST)) burst_q <= bus_wdata[CNT_W-1:0];
      if (bus_wr && (bus_addr == OFF_TXCNT)) txcnt_q <= bus_wdata[CNT_W-1:0];
      if (eng_done)                             ist_q <= 1'b1;   // R11
      else if (wr_ist && bus_wdata[IB_DONE])    ist_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_RXD: bus_rdata[7:0] = rx_head;
      OFF_CTRL: begin
        bus_rdata[CB_EN]       = en_q;
        bus_rdata[CB_MSTR]     = mstr_q;
        bus_rdata[CB_CPHA]     = cpha_q;
        bus_rdata[CB_CPOL]     = cpol_q;
        bus_rdata[CB_ACTLOW]   = al_q;
        bus_rdata[CB_LSB]      = lsb_q;
        bus_rdata[CB_GO]       = eng_busy || go_q;          // R4
        bus_rdata[CB_SEL +: SW] = sel_q;
        bus_rdata[CB_DISCARD]  = discard_q;
        bus_rdata[CB_MANUAL]   = manual_q;
        bus_rdata[CB_LEVEL]    = level_q;
      end
      OFF_IEN:   bus_rdata[IB_DONE] = ien_q;
      OFF_IST:   bus_rdata[IB_DONE] = ist_q;
      OFF_BURST: bus_rdata[CNT_W-1:0] = burst_q;
      OFF_TXCNT: bus_rdata[CNT_W-1:0] = txcnt_q;
      OFF_FSTAT: begin
        bus_rdata[CW-1:0]          = rx_count;   // R2
        bus_rdata[FS_TXPOS +: CW]  = tx_count;
      end
      default: bus_rdata = '0;
    endcase
    irq = ist_q && ien_q;                          // R11
  end

  AST_DONE_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n) eng_done |=> ist_q); // R11
  AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (!rst_n) (eng_busy && !manual_q) |-> ($countones(spi_cs ^ {NCS{al_q}}) == 1)); // R9
endmodule

// File: tb/sim_spi_burst_master.sv
module sim_spi_burst_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick = 1'b0;
  logic        sck, mosi, irq;
  logic [3:0]  cs;

  always #4 clk = ~clk;   // 125 MHz

  spi_burst_master u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_tick(tick), .spi_sck(sck),
    .spi_mosi(mosi), .spi_miso(mosi), .spi_cs(cs), .irq(irq)
  );

  localparam logic [31:0] C_EN = 32'h1, C_MSTR = 32'h2, C_CPHA = 32'h4, C_CPOL = 32'h8;
  localparam logic [31:0] C_AL = 32'h10, C_LSB = 32'h40, C_TXCLR = 32'h100, C_RXCLR = 32'h200;
  localparam logic [31:0] C_GO = 32'h400, C_DISC = 32'h8000, C_MAN = 32'h10000, C_LVL = 32'h20000;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
    tick = (tdiv == 0);
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  // scoreboard: driver side pushes expected line bytes, monitor pops
  logic [7:0] exp_q[$];
  logic m_cpol = 0, m_cpha = 0, m_lsb = 0, m_al = 0, mon_en = 0;
  logic [1:0] m_sel = 0;
  logic prev_sck = 0, prev_act = 0;
  logic [7:0] sh = 0;
  int nb = 0, edges = 0;

  always @(negedge clk) begin
    if (sck !== prev_sck) begin
      edges++;
      if (mon_en && prev_act && ((sck != m_cpol) == !m_cpha)) begin
        sh = m_lsb ? {mosi, sh[7:1]} : {sh[6:0], mosi};
        nb++;
        if (nb == 8) begin
          nb = 0;
          if (exp_q.size() == 0) check("R5 surplus byte on line", {24'h0, sh}, 32'hFFFF_FFFF);
          else check("R5 R6 R7 line byte", {24'h0, sh}, {24'h0, exp_q.pop_front()});
        end
      end
    end
    prev_sck = sck;
    prev_act = m_al ? !cs[m_sel] : cs[m_sel];
  end

  task automatic prep(input logic [31:0] c);
    mon_en = 0;
    wr(6'h08, c);
    repeat (2) @(negedge clk);
    m_cpol = c[3]; m_cpha = c[2]; m_lsb = c[6]; m_al = c[4]; m_sel = c[13:12];
    nb = 0;
    @(negedge clk);
    mon_en = 1;
  endtask

  task automatic push_tx(input logic [7:0] b, input bit line);
    wr(6'h04, {24'h0, b});
    if (line) exp_q.push_back(b);
  endtask

  task automatic wait_done();
    logic [31:0] d = 0;
    for (int i = 0; i < 4000; i++) begin
      rd(6'h10, d);
      if (d[16]) break;
    end
    check("R11 completion flag", {31'h0, d[16]}, 32'h1);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(6'h08, d); check("R1 ctrl", d, 0);
    rd(6'h28, d); check("R1 fifo status", d, 0);
    check("R1 sck", {31'h0, sck}, 0);
    check("R1 cs", {28'h0, cs}, 0);
    check("R1 irq", {31'h0, irq}, 0);

    // R2 fill level, R3 reset
    for (int i = 0; i < 5; i++) push_tx(8'(i), 0);
    rd(6'h28, d); check("R2 tx level 5", d, 32'h0005_0000);
    wr(6'h08, C_TXCLR);
    rd(6'h28, d); check("R3 tx cleared", d, 0);
    for (int i = 0; i < 65; i++) push_tx(8'(i), 0);
    rd(6'h28, d); check("R2 tx capped at 64", d, 32'h0040_0000);
    wr(6'h08, C_TXCLR);
    rd(6'h28, d); check("R3 tx cleared after full", d, 0);

    // R4 go without enable
    wr(6'h20, 1);
    wr(6'h08, C_GO);
    repeat (4) @(negedge clk);
    rd(6'h08, d); check("R4 no start without enable", d, 0);
    rd(6'h10, d); check("R4 no completion without enable", d, 0);

    // burst 1: mode 0, MSB first, active-low cs on line 2
    prep(C_EN | C_MSTR | C_AL | (32'd2 << 12));
    check("R9 idle lines high", {28'h0, cs}, 32'hF);
    check("R5 idle sck cpol0", {31'h0, sck}, 0);
    push_tx(8'hA5, 1); push_tx(8'h3C, 1); push_tx(8'h81, 1);
    wr(6'h0C, 32'h1_0000);
    wr(6'h20, 3); wr(6'h24, 3);
    wr(6'h08, C_EN | C_MSTR | C_AL | (32'd2 << 12) | C_GO);
    repeat (6) @(negedge clk);
    check("R9 line 2 active low", {28'h0, cs}, 32'hB);
    rd(6'h08, d); check("R4 go reads 1 while busy", {31'h0, d[10]}, 1);
    check("R11 irq low mid burst", {31'h0, irq}, 0);
    wait_done();
    check("R11 irq raised", {31'h0, irq}, 1);
    rd(6'h08, d); check("R4 go self-clears", d, C_EN | C_MSTR | C_AL | (32'd2 << 12));
    check("R9 line released", {28'h0, cs}, 32'hF);
    check("R5 all bytes shifted", exp_q.size(), 0);
    rd(6'h28, d); check("R8 rx level 3", d, 3);
    rd(6'h00, d); check("R8 rx byte 0", d, 32'hA5);
    rd(6'h00, d); check("R8 rx byte 1", d, 32'h3C);
    rd(6'h00, d); check("R8 rx byte 2", d, 32'h81);
    wr(6'h10, 32'h1_0000);
    check("R11 irq cleared", {31'h0, irq}, 0);
    rd(6'h10, d); check("R11 status cleared", d, 0);

    // burst 2: mode 3, LSB first, active-high cs line 0, short tx count
    prep(C_EN | C_CPOL | C_CPHA | C_LSB);
    check("R5 idle sck cpol1", {31'h0, sck}, 1);
    check("R9 idle lines low", {28'h0, cs}, 0);
    push_tx(8'hC3, 1); push_tx(8'h12, 1);
    exp_q.push_back(8'h00); exp_q.push_back(8'h00);
    wr(6'h20, 4); wr(6'h24, 2);
    wr(6'h08, C_EN | C_CPOL | C_CPHA | C_LSB | C_GO);
    repeat (6) @(negedge clk);
    check("R9 line 0 active high", {28'h0, cs}, 32'h1);
    wait_done();
    check("R7 R6 all bytes shifted", exp_q.size(), 0);
    rd(6'h28, d); check("R8 rx level 4", d, 4);
    rd(6'h00, d); check("R7 rx byte 0", d, 32'hC3);
    rd(6'h00, d); check("R7 rx byte 1", d, 32'h12);
    rd(6'h00, d); check("R7 zero fill 2", d, 0);
    rd(6'h00, d); check("R7 zero fill 3", d, 0);
    wr(6'h10, 32'h1_0000);

    // burst 3: mode 1, discard received bytes
    prep(C_EN | C_CPHA | C_AL | C_DISC | (32'd1 << 12));
    push_tx(8'h6E, 1);
    wr(6'h20, 1); wr(6'h24, 1);
    wr(6'h08, C_EN | C_CPHA | C_AL | C_DISC | (32'd1 << 12) | C_GO);
    wait_done();
    check("R5 mode 1 byte shifted", exp_q.size(), 0);
    rd(6'h28, d); check("R8 discard keeps rx empty", d, 0);
    wr(6'h10, 32'h1_0000);

    // burst 4: mode 2, LSB first, line 3
    prep(C_EN | C_CPOL | C_LSB | C_AL | (32'd3 << 12));
    push_tx(8'h9B, 1);
    wr(6'h20, 1); wr(6'h24, 1);
    wr(6'h08, C_EN | C_CPOL | C_LSB | C_AL | (32'd3 << 12) | C_GO);
    wait_done();
    check("R6 mode 2 byte shifted", exp_q.size(), 0);
    rd(6'h28, d); check("R8 rx level 1", d, 1);
    wr(6'h08, C_EN | C_CPOL | C_LSB | C_AL | (32'd3 << 12) | C_RXCLR);
    rd(6'h28, d); check("R3 rx cleared", d, 0);
    wr(6'h10, 32'h1_0000);

    // R12 zero-length burst, interrupt masked
    wr(6'h0C, 0);
    wr(6'h20, 0);
    e0 = edges;
    wr(6'h08, C_EN | C_CPOL | C_LSB | C_AL | (32'd3 << 12) | C_GO);
    repeat (3) @(negedge clk);
    rd(6'h10, d); check("R12 immediate completion", d, 32'h1_0000);
    check("R12 no sck edges", edges - e0, 0);
    check("R11 masked irq", {31'h0, irq}, 0);
    rd(6'h08, d); check("R4 go clear after empty burst", {31'h0, d[10]}, 0);
    wr(6'h10, 32'h1_0000);

    // R10 manual chip select
    mon_en = 0;
    wr(6'h08, C_EN | C_AL | C_MAN | C_LVL | (32'd1 << 12));
    check("R10 manual high", {28'h0, cs}, 32'hF);
    wr(6'h08, C_EN | C_AL | C_MAN | (32'd1 << 12));
    check("R10 manual low", {28'h0, cs}, 32'hD);
    wr(6'h08, C_EN | C_MAN | C_LVL | (32'd3 << 12));
    check("R10 manual high, idle low", {28'h0, cs}, 32'h8);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule